// File: doc/BRIEF.md
# External Interrupt Controller Bank

This block gathers 32 external interrupt lines and merges them into one interrupt request for a processor. Each line first passes through a two-flop synchroniser. It is then judged by its own sensitivity and polarity settings. A line in edge mode latches a pending bit on its active transition, and that bit stays set until software acknowledges it. A line in level mode shows its active level directly as pending. Software can also force any line active with a soft-trigger bit. This lets a handler replay an event it may have missed while it switched a line between rising and falling detection.

Software configures the bank over a simple word-write register bus with a combinational read port. Mask, sensitivity, soft-trigger and polarity each have a read-only view and two aliases. Writing 1s to the set alias sets the matching bits, and writing 1s to the clear alias clears them. A domain-enable word, written directly, acts as a second gate after the mask. The bank leaves reset with every line masked and every domain bit enabled, so nothing reaches the request output until software unmasks a line.

Top module: `ext_irq_bank`

## Requirements
- R1: After reset the mask and domain-enable words read 0xFFFFFFFF; sensitivity, polarity, soft and pending read 0; `irq_o` is low.
- R2: The mask is changed only through its aliases. A 1 written to the set alias sets that bit, a 1 written to the clear alias clears it, and 0 data bits leave bits unchanged. A write to the mask view address changes nothing.
- R3: With polarity 1 in edge mode, a 0-to-1 change of the synchronised pin sets that channel's pending bit. The bit stays set after the pin returns low, and a falling change does not set it.
- R4: With polarity 0 in edge mode, a 1-to-0 change sets the pending bit and a 0-to-1 change does not.
- R5: An acknowledge write clears exactly the edge-latched pending bits whose data bits are 1. Other latched bits stay set.
- R6: With sensitivity 1 (level mode), the pending bit equals the pin XNOR polarity and follows the pin in both directions. An acknowledge write has no effect on it, and no edge latch is kept while in level mode.
- R7: A soft bit raises `irq_o` for an unmasked channel until it is cleared through the soft-clear alias. Acknowledge does not clear it.
- R8: `irq_o` is the OR over channels of (pending OR soft) AND NOT mask AND domain-enable. The pending read shows the value before the mask and excludes soft bits.
- R9: The domain-enable word is written directly. A 0 bit there blocks that channel from `irq_o` even when it is unmasked and pending.
- R10: Sensitivity, polarity and soft use the same set/clear alias scheme as the mask and read back through their views.
- R11: Addresses outside the map, and word indexes beyond the configured count, read 0 and accept writes without effect. The acknowledge and alias addresses read 0.
- R12: Byte offsets are: pending 0x000, acknowledge 0x040, mask 0x080/set 0x0C0/clear 0x100, sensitivity 0x140/0x180/0x1C0, soft 0x200/0x240/0x280, polarity 0x300/0x340/0x380, domain-enable 0x400. Word k of each register is at offset + 4k, and channel n uses bit n mod 32 of word n/32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 32*NUM_WORDS | External interrupt lines, asynchronous |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a fully masked bank or a cleared domain word keeps `irq_o` low. They also check that an unmasked, enabled soft bit always drives it, that writes to the mask view never change the mask, and that no edge latch survives in level mode. Only the directed scenarios can show the pin-to-pending latency through the synchroniser, the direction each polarity detects, the selective action of acknowledge, the level-follow behaviour, and the read values of the alias and unmapped addresses.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int RGN_W  = ADDR_W - 6;

  localparam logic [RGN_W-1:0] RG_PEND     = 6'h00;
  localparam logic [RGN_W-1:0] RG_ACK      = 6'h01;
  localparam logic [RGN_W-1:0] RG_MASK     = 6'h02;
  localparam logic [RGN_W-1:0] RG_MASK_SET = 6'h03;
  localparam logic [RGN_W-1:0] RG_MASK_CLR = 6'h04;
  localparam logic [RGN_W-1:0] RG_SENS     = 6'h05;
  localparam logic [RGN_W-1:0] RG_SENS_SET = 6'h06;
  localparam logic [RGN_W-1:0] RG_SENS_CLR = 6'h07;
  localparam logic [RGN_W-1:0] RG_SOFT     = 6'h08;
  localparam logic [RGN_W-1:0] RG_SOFT_SET = 6'h09;
  localparam logic [RGN_W-1:0] RG_SOFT_CLR = 6'h0A;
  localparam logic [RGN_W-1:0] RG_POL      = 6'h0C;
  localparam logic [RGN_W-1:0] RG_POL_SET  = 6'h0D;
  localparam logic [RGN_W-1:0] RG_POL_CLR  = 6'h0E;
  localparam logic [RGN_W-1:0] RG_DOM      = 6'h10;
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eirq_setclr_reg.sv
`timescale 1ns/1ps
module eirq_setclr_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic         ld_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  always_comb begin
    val_d = val_q;
    if (ld_en_i) begin
      val_d = wdata_i;
    end else begin
      if (set_en_i) val_d = val_d | wdata_i;
      if (clr_en_i) val_d = val_d & ~wdata_i;
    end
    val_en = ld_en_i | set_en_i | clr_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RST_VAL;
    else if (val_en) val_q <= val_d;
  end

  assign q_o = val_q;
endmodule

// File: rtl/eirq_detect.sv
`timescale 1ns/1ps
module eirq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] sens_i,
  input  logic [W-1:0] pol_i,
  input  logic         ack_en_i,
  input  logic [W-1:0] ack_bits_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] lat_d;
  logic         lat_en;
  logic [W-1:0] edge_hit;
  logic [W-1:0] lvl_act;
  logic [W-1:0] ack_clr;

  always_comb begin
    lvl_act  = ~(pin_s_i ^ pol_i);
    edge_hit = (pol_i & pin_s_i & ~prev_q) | (~pol_i & ~pin_s_i & prev_q);
    ack_clr  = ack_en_i ? ack_bits_i : '0;
    lat_d    = ~sens_i & ((lat_q & ~ack_clr) | edge_hit);
    lat_en   = (lat_d != lat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign pend_o = (sens_i & lvl_act) | (~sens_i & lat_q);
  assign lat_o  = lat_q;
endmodule

// File: rtl/ext_irq_bank.sv
`timescale 1ns/1ps
module ext_irq_bank
  import eirq_pkg::*;
#(
  parameter int NUM_WORDS = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS*WORD_W-1:0] pin_i,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [WORD_W-1:0]           bus_wdata_i,
  output logic [WORD_W-1:0]           bus_rdata_o,
  output logic                        irq_o
);
  localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [RGN_W-1:0] rgn;
  logic [3:0]       widx;
  logic             unused_addr_lo;

  assign rgn            = bus_addr_i[ADDR_W-1:6];
  assign widx           = bus_addr_i[5:2];
  assign unused_addr_lo = ^bus_addr_i[1:0];

  logic [NUM_WORDS-1:0][WORD_W-1:0] mask_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] sens_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] soft_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] pol_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] dom_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] pend_w;
  logic [NUM_WORDS-1:0][WORD_W-1:0] lat_all;
  logic [NUM_WORDS-1:0][WORD_W-1:0] req_w;
  logic [NUM_WORDS-1:0][WORD_W-1:0] pin_s;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic wsel;
    assign wsel = bus_wr_i && (widx == 4'(w));

    eirq_sync #(.W(WORD_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .d_i   (pin_i[w*WORD_W +: WORD_W]),
      .q_o   (pin_s[w])
    );

    eirq_setclr_reg #(.W(WORD_W), .RST_VAL(ALL_ONES)) u_mask (
      .clk(clk), .rst_n(rst_sync_n),
      .set_en_i(wsel && rgn == RG_MASK_SET),
      .clr_en_i(wsel && rgn == RG_MASK_CLR),
      .ld_en_i(1'b0), .wdata_i(bus_wdata_i), .q_o(mask_q[w])
    );

    eirq_setclr_reg #(.W(WORD_W), .RST_VAL('0)) u_sens (
      .clk(clk), .rst_n(rst_sync_n),
      .set_en_i(wsel && rgn == RG_SENS_SET),
      .clr_en_i(wsel && rgn == RG_SENS_CLR),
      .ld_en_i(1'b0), .wdata_i(bus_wdata_i), .q_o(sens_q[w])
    );

    eirq_setclr_reg #(.W(WORD_W), .RST_VAL('0)) u_soft (
      .clk(clk), .rst_n(rst_sync_n),
      .set_en_i(wsel && rgn == RG_SOFT_SET),
      .clr_en_i(wsel && rgn == RG_SOFT_CLR),
      .ld_en_i(1'b0), .wdata_i(bus_wdata_i), .q_o(soft_q[w])
    );

    eirq_setclr_reg #(.W(WORD_W), .RST_VAL('0)) u_pol (
      .clk(clk), .rst_n(rst_sync_n),
      .set_en_i(wsel && rgn == RG_POL_SET),
      .clr_en_i(wsel && rgn == RG_POL_CLR),
      .ld_en_i(1'b0), .wdata_i(bus_wdata_i), .q_o(pol_q[w])
    );

    eirq_setclr_reg #(.W(WORD_W), .RST_VAL(ALL_ONES)) u_dom (
      .clk(clk), .rst_n(rst_sync_n),
      .set_en_i(1'b0), .clr_en_i(1'b0),
      .ld_en_i(wsel && rgn == RG_DOM),
      .wdata_i(bus_wdata_i), .q_o(dom_q[w])
    );

    eirq_detect #(.W(WORD_W)) u_det (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .pin_s_i    (pin_s[w]),
      .sens_i     (sens_q[w]),
      .pol_i      (pol_q[w]),
      .ack_en_i   (wsel && rgn == RG_ACK),
      .ack_bits_i (bus_wdata_i),
      .pend_o     (pend_w[w]),
      .lat_o      (lat_all[w])
    );

    assign req_w[w] = (pend_w[w] | soft_q[w]) & ~mask_q[w] & dom_q[w];
  end

  assign irq_o = |req_w;

  always_comb begin
    bus_rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (widx == 4'(w)) begin
        case (rgn)
          RG_PEND: bus_rdata_o = pend_w[w];
          RG_MASK: bus_rdata_o = mask_q[w];
          RG_SENS: bus_rdata_o = sens_q[w];
          RG_SOFT: bus_rdata_o = soft_q[w];
          RG_POL:  bus_rdata_o = pol_q[w];
          RG_DOM:  bus_rdata_o = dom_q[w];
          default: bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eirq_chk.sv
`timescale 1ns/1ps
module eirq_chk
  import eirq_pkg::*;
#(
  parameter int NUM_WORDS = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_wr_i,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic                        irq_o,
  input logic [NUM_WORDS*WORD_W-1:0] mask_f,
  input logic [NUM_WORDS*WORD_W-1:0] dom_f,
  input logic [NUM_WORDS*WORD_W-1:0] soft_f,
  input logic [NUM_WORDS*WORD_W-1:0] sens_f,
  input logic [NUM_WORDS*WORD_W-1:0] lat_f
);
  // R8: a fully masked bank never requests
  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_f) |-> !irq_o);

  // R9: a cleared domain word blocks everything
  assert_domain_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_f == '0) |-> !irq_o);

  // R7: an enabled, unmasked soft bit always raises the request
  assert_soft_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(soft_f & ~mask_f & dom_f)) |-> irq_o);

  // R2: a write to the mask view address leaves the mask untouched
  assert_mask_view_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i[ADDR_W-1:6] == RG_MASK) |=> $stable(mask_f));

  // R6: no edge latch is held by a channel that stays in level mode
  assert_level_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sens_f & $past(sens_f) & lat_f) == '0));
endmodule

bind ext_irq_bank eirq_chk #(.NUM_WORDS(NUM_WORDS)) u_eirq_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .irq_o      (irq_o),
  .mask_f     (mask_q),
  .dom_f      (dom_q),
  .soft_f     (soft_q),
  .sens_f     (sens_q),
  .lat_f      (lat_all)
);

// File: tb/tb_ext_irq_bank.sv
`timescale 1ns/1ps
module tb_ext_irq_bank;
  localparam logic [11:0] A_PEND = 12'h000, A_ACK = 12'h040, A_MASK = 12'h080,
    A_MSET = 12'h0C0, A_MCLR = 12'h100, A_SENS = 12'h140, A_SSET = 12'h180,
    A_SCLR = 12'h1C0, A_SOFT = 12'h200, A_FSET = 12'h240, A_FCLR = 12'h280,
    A_POL = 12'h300, A_PSET = 12'h340, A_PCLR = 12'h380, A_DOM = 12'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_bank #(.NUM_WORDS(1)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    #1;
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 mask", A_MASK, 32'hFFFF_FFFF);
    rd_chk("R1 dom", A_DOM, 32'hFFFF_FFFF);
    rd_chk("R1 sens", A_SENS, 32'h0);
    rd_chk("R1 pol", A_POL, 32'h0);
    rd_chk("R1 soft", A_SOFT, 32'h0);
    rd_chk("R1 pend", A_PEND, 32'h0);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_mask_alias();
    wr_word(A_MCLR, 32'h0000_00F0);
    rd_chk("R2 clear alias", A_MASK, 32'hFFFF_FF0F);
    wr_word(A_MSET, 32'h0000_0010);
    rd_chk("R2 set alias", A_MASK, 32'hFFFF_FF1F);
    wr_word(A_MASK, 32'h0);
    rd_chk("R2 view write ignored", A_MASK, 32'hFFFF_FF1F);
    wr_word(A_MSET, 32'hFFFF_FFFF);
    rd_chk("R2 restore", A_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic t_other_alias();
    wr_word(A_SSET, 32'h0000_00A5);
    rd_chk("R10 sens set", A_SENS, 32'h0000_00A5);
    wr_word(A_SCLR, 32'h0000_0005);
    rd_chk("R10 sens clear", A_SENS, 32'h0000_00A0);
    wr_word(A_SCLR, 32'hFFFF_FFFF);
    wr_word(A_PSET, 32'h0000_003C);
    wr_word(A_PCLR, 32'h0000_000C);
    rd_chk("R10 pol set/clear", A_POL, 32'h0000_0030);
    wr_word(A_PCLR, 32'hFFFF_FFFF);
    wr_word(A_FSET, 32'h0000_0081);
    rd_chk("R10 soft set", A_SOFT, 32'h0000_0081);
    wr_word(A_FCLR, 32'h0000_0081);
    rd_chk("R10 soft clear", A_SOFT, 32'h0);
    rd_chk("R10 pend after cleanup", A_PEND, 32'h0);
  endtask

  task automatic t_rising();
    wr_word(A_PSET, 32'h1);
    settle();
    @(negedge clk); pin[0] = 1'b0;
    rd_chk("R3 no edge yet", A_PEND, 32'h0);
    @(negedge clk); pin[0] = 1'b1;
    settle();
    rd_chk("R3 rising latched", A_PEND, 32'h1);
    @(negedge clk); pin[0] = 1'b0;
    settle();
    rd_chk("R3 held after pin low", A_PEND, 32'h1);
    irq_chk("R8 masked pending gives no irq", 1'b0);
    wr_word(A_MCLR, 32'h1);
    irq_chk("R8 unmasked pending raises irq", 1'b1);
    wr_word(A_ACK, 32'h2);
    rd_chk("R5 other-bit ack keeps bit", A_PEND, 32'h1);
    wr_word(A_ACK, 32'h1);
    rd_chk("R5 ack clears bit", A_PEND, 32'h0);
    irq_chk("R5 irq drops after ack", 1'b0);
    wr_word(A_MSET, 32'h1);
  endtask

  task automatic t_falling();
    @(negedge clk); pin[3] = 1'b1;
    settle();
    rd_chk("R4 rising ignored", A_PEND, 32'h0);
    @(negedge clk); pin[3] = 1'b0;
    settle();
    rd_chk("R4 falling latched", A_PEND, 32'h8);
    wr_word(A_ACK, 32'h8);
    rd_chk("R4 cleared", A_PEND, 32'h0);
  endtask

  task automatic t_level();
    wr_word(A_PSET, 32'h20);
    wr_word(A_SSET, 32'h20);
    rd_chk("R6 inactive level", A_PEND, 32'h0);
    @(negedge clk); pin[5] = 1'b1;
    settle();
    rd_chk("R6 active level", A_PEND, 32'h20);
    wr_word(A_ACK, 32'h20);
    rd_chk("R6 ack no effect", A_PEND, 32'h20);
    wr_word(A_MCLR, 32'h20);
    irq_chk("R6 level irq", 1'b1);
    @(negedge clk); pin[5] = 1'b0;
    settle();
    rd_chk("R6 follows pin low", A_PEND, 32'h0);
    irq_chk("R6 irq follows", 1'b0);
    wr_word(A_MSET, 32'h20);
    wr_word(A_SCLR, 32'h20);
    rd_chk("R6 back to edge, nothing latched", A_PEND, 32'h0);
  endtask

  task automatic t_soft();
    wr_word(A_FSET, 32'h80);
    wr_word(A_MCLR, 32'h80);
    irq_chk("R7 soft raises irq", 1'b1);
    rd_chk("R8 pend excludes soft", A_PEND, 32'h0);
    wr_word(A_ACK, 32'h80);
    irq_chk("R7 ack keeps soft", 1'b1);
    wr_word(A_FCLR, 32'h80);
    irq_chk("R7 soft clear drops irq", 1'b0);
    wr_word(A_MSET, 32'h80);
  endtask

  task automatic t_domain();
    @(negedge clk); pin[0] = 1'b1;
    settle();
    wr_word(A_MCLR, 32'h1);
    irq_chk("R9 enabled path", 1'b1);
    wr_word(A_DOM, 32'hFFFF_FFFE);
    rd_chk("R9 dom readback", A_DOM, 32'hFFFF_FFFE);
    irq_chk("R9 domain blocks", 1'b0);
    wr_word(A_DOM, 32'hFFFF_FFFF);
    irq_chk("R9 domain restored", 1'b1);
    wr_word(A_ACK, 32'h1);
    wr_word(A_MSET, 32'h1);
    irq_chk("R9 quiet after cleanup", 1'b0);
  endtask

  task automatic t_unmapped();
    wr_word(12'hB00, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped reads 0", 12'hB00, 32'h0);
    wr_word(12'h084, 32'h0);
    rd_chk("R11 out-of-range word reads 0", 12'h084, 32'h0);
    rd_chk("R11 mask unaffected", A_MASK, 32'hFFFF_FFFF);
    rd_chk("R11 ack reads 0", A_ACK, 32'h0);
    rd_chk("R11 alias reads 0", A_MCLR, 32'h0);
    rd_chk("R12 dom offset", A_DOM, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_mask_alias();
    t_other_alias();
    t_rising();
    t_falling();
    t_level();
    t_soft();
    t_domain();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule